// File: doc/BRIEF.md
# Multi-Mode Storage Register with Clock Enable

This block is one configurable storage bit. A static mode field makes it behave as a D, T, JK or SR edge-triggered flip-flop, or as a level-sensitive transparent latch. Two data inputs feed it. `din_a` is the D, T, J or S input, and `din_b` is the K or R input. The clock may come either from the shared global clock or from a per-cell product-term clock. When the global clock is chosen, a product-term clock enable can be switched in to make the register skip edges.

Asynchronous clearing comes from one of four sources, picked by a select field: nothing, the active-low global clear, a local clear term, or the OR of those two. Asynchronous setting is either a local set term or disabled. When a clear and a set are active together, the clear wins. The flip-flop and latch storage both start at 0 once the clear has been applied. Internally, the stored bit is a two-state machine (`ST_ZERO`, `ST_ONE`). Its next-state logic takes one of four named transitions: `TR_HOLD`, `TR_SET`, `TR_CLEAR` or `TR_TOGGLE`.

Top module: `multimode_reg`

## Requirements
- R1: With `mode` = 0 (D), the register loads `din_a` on a rising edge of the selected clock. Codes 5 to 7 also behave as D.
- R2: With `mode` = 1 (T), a rising edge inverts `q` when `din_a` = 1 and keeps `q` when `din_a` = 0.
- R3: With `mode` = 2 (JK, J = `din_a`, K = `din_b`), a rising edge behaves as follows: 00 keeps `q`, 10 sets it, 01 clears it, 11 inverts it.
- R4: With `mode` = 3 (SR, S = `din_a`, R = `din_b`), a rising edge behaves as follows: 10 sets `q`, 01 clears it, 00 and 11 both keep it.
- R5: With `mode` = 4 (latch), `q` follows `din_a` while the selected clock is high and holds its value while that clock is low.
- R6: `clk_sel` = 0 selects `clk_glb` and `clk_sel` = 1 selects `clk_pt`. Edges on the clock that is not selected have no effect.
- R7: When `clk_sel` = 0 and `ce_use` = 1, a global-clock edge with `ce_pt` = 0 is ignored, and an edge with `ce_pt` = 1 is taken. When `clk_sel` = 1, `ce_use` and `ce_pt` have no effect.
- R8: `ar_sel` picks the asynchronous clear source: 0 none, 1 global clear (`gclr_n` = 0), 2 `ar_pt` = 1, 3 either of these. While the chosen clear is active, `q` = 0.
- R9: With `ap_en` = 1, `ap_pt` = 1 forces `q` = 1 asynchronously, and `q` stays at 1 after `ap_pt` is released. With `ap_en` = 0, `ap_pt` has no effect.
- R10: When the asynchronous clear and the asynchronous set are active together, `q` = 0.
- R11: With `ar_sel` = 1, pulling `gclr_n` low brings `q` to 0 from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_glb | input | 1 | Global clock |
| clk_pt | input | 1 | Per-cell product-term clock |
| clk_sel | input | 1 | Clock source: 0 global, 1 product term |
| ce_use | input | 1 | Enables the clock-enable function (global clock only) |
| ce_pt | input | 1 | Clock-enable term, active high |
| mode | input | 3 | Storage behaviour: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| din_a | input | 1 | D / T / J / S input |
| din_b | input | 1 | K / R input |
| gclr_n | input | 1 | Global asynchronous clear, active low |
| ar_pt | input | 1 | Local asynchronous clear term, active high |
| ar_sel | input | 2 | Clear source: 0 none, 1 global, 2 local, 3 both |
| ap_pt | input | 1 | Local asynchronous set term, active high |
| ap_en | input | 1 | Enables the asynchronous set term |
| q | output | 1 | Stored value |

## Verification
The hardest case to reach from the ports is a clock edge that should change nothing: an edge on the unselected clock, or a global edge taken while the enable term is low. Such an edge only counts as a test when the data input would have moved `q`. For that reason, the bench first loads the opposite of the pending data value and then drives the ignored edges. Changing the clock source can itself produce a spurious rising edge. To avoid this, the bench switches the source only while both clocks are low. Every asynchronous clear or set is held across the following global edge, so that each edge it overlaps is accounted for.

// File: rtl/multimode_reg_pkg.sv
package multimode_reg_pkg;

    typedef enum logic [2:0] {
        MD_D     = 3'd0,
        MD_T     = 3'd1,
        MD_JK    = 3'd2,
        MD_SR    = 3'd3,
        MD_LATCH = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        AR_OFF   = 2'd0,
        AR_GLB   = 2'd1,
        AR_LOCAL = 2'd2,
        AR_BOTH  = 2'd3
    } ar_src_e;

    typedef enum logic {
        ST_ZERO = 1'b0,
        ST_ONE  = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        TR_HOLD   = 2'd0,
        TR_SET    = 2'd1,
        TR_CLEAR  = 2'd2,
        TR_TOGGLE = 2'd3
    } trans_e;

endpackage

// File: rtl/multimode_reg_next.sv
module multimode_reg_next
    import multimode_reg_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       in_a,
    input  logic       in_b,
    input  state_e     cur,
    output state_e     nxt
);

    trans_e trans;

    // Transition selection per storage behaviour
    always_comb begin
        trans = TR_HOLD;
        case (mode)
            MD_T: begin
                trans = in_a ? TR_TOGGLE : TR_HOLD;
            end
            MD_JK: begin
                case ({in_a, in_b})
                    2'b10:   trans = TR_SET;
                    2'b01:   trans = TR_CLEAR;
                    2'b11:   trans = TR_TOGGLE;
                    default: trans = TR_HOLD;
                endcase
            end
            MD_SR: begin
                case ({in_a, in_b})
                    2'b10:   trans = TR_SET;
                    2'b01:   trans = TR_CLEAR;
                    default: trans = TR_HOLD;
                endcase
            end
            default: begin
                trans = in_a ? TR_SET : TR_CLEAR;
            end
        endcase
    end

    // Next state from the chosen transition
    always_comb begin
        unique case (trans)
            TR_HOLD:   nxt = cur;
            TR_SET:    nxt = ST_ONE;
            TR_CLEAR:  nxt = ST_ZERO;
            TR_TOGGLE: nxt = (cur == ST_ONE) ? ST_ZERO : ST_ONE;
        endcase
    end

endmodule

// File: rtl/multimode_reg_clk.sv
module multimode_reg_clk (
    input  logic clk_glb,
    input  logic clk_pt,
    input  logic clk_sel,
    input  logic ce_use,
    input  logic ce_pt,
    output logic clk_eff,
    output logic ce_ok
);

    always_comb begin
        clk_eff = clk_sel ? clk_pt : clk_glb;
        // The enable only gates the global clock
        ce_ok   = clk_sel | ~ce_use | ce_pt;
    end

endmodule

// File: rtl/multimode_reg_async.sv
module multimode_reg_async
    import multimode_reg_pkg::*;
(
    input  logic       gclr_n,
    input  logic       ar_pt,
    input  logic [1:0] ar_sel,
    input  logic       ap_pt,
    input  logic       ap_en,
    output logic       arst,
    output logic       apst
);

    ar_src_e src;

    always_comb begin
        src = ar_src_e'(ar_sel);
        unique case (src)
            AR_OFF:   arst = 1'b0;
            AR_GLB:   arst = ~gclr_n;
            AR_LOCAL: arst = ar_pt;
            AR_BOTH:  arst = ~gclr_n | ar_pt;
        endcase
        // Clear has priority over set
        apst = ap_en & ap_pt & ~arst;
    end

endmodule

// File: rtl/multimode_reg.sv
module multimode_reg
    import multimode_reg_pkg::*;
(
    input  logic       clk_glb,
    input  logic       clk_pt,
    input  logic       clk_sel,
    input  logic       ce_use,
    input  logic       ce_pt,
    input  logic [2:0] mode,
    input  logic       din_a,
    input  logic       din_b,
    input  logic       gclr_n,
    input  logic       ar_pt,
    input  logic [1:0] ar_sel,
    input  logic       ap_pt,
    input  logic       ap_en,
    output logic       q
);

    logic   clk_eff;
    logic   ce_ok;
    logic   arst;
    logic   apst;
    state_e ff_state;
    state_e ff_next;
    state_e lat_state;

    multimode_reg_clk u_clk (
        .clk_glb (clk_glb),
        .clk_pt  (clk_pt),
        .clk_sel (clk_sel),
        .ce_use  (ce_use),
        .ce_pt   (ce_pt),
        .clk_eff (clk_eff),
        .ce_ok   (ce_ok)
    );

    multimode_reg_async u_async (
        .gclr_n (gclr_n),
        .ar_pt  (ar_pt),
        .ar_sel (ar_sel),
        .ap_pt  (ap_pt),
        .ap_en  (ap_en),
        .arst   (arst),
        .apst   (apst)
    );

    multimode_reg_next u_next (
        .mode (mode),
        .in_a (din_a),
        .in_b (din_b),
        .cur  (ff_state),
        .nxt  (ff_next)
    );

    // Edge-triggered state register
    always_ff @(posedge clk_eff or posedge arst or posedge apst) begin
        if (arst) begin
            ff_state <= ST_ZERO;
        end else if (apst) begin
            ff_state <= ST_ONE;
        end else if (ce_ok) begin
            ff_state <= ff_next;
        end
    end

    // Level-sensitive storage for latch mode
    always_latch begin
        if (arst) begin
            lat_state <= ST_ZERO;
        end else if (apst) begin
            lat_state <= ST_ONE;
        end else if (clk_eff && ce_ok) begin
            lat_state <= din_a ? ST_ONE : ST_ZERO;
        end
    end

    // Output selection
    always_comb begin
        q = (mode == MD_LATCH) ? (lat_state == ST_ONE) : (ff_state == ST_ONE);
    end

endmodule

// File: rtl/multimode_reg_chk.sv
module multimode_reg_chk (
    input logic       clk_glb,
    input logic       clk_sel,
    input logic       ce_use,
    input logic       ce_pt,
    input logic [2:0] mode,
    input logic       din_a,
    input logic       gclr_n,
    input logic       ar_pt,
    input logic [1:0] ar_sel,
    input logic       ap_pt,
    input logic       ap_en,
    input logic       q
);

    logic clr_on;
    logic set_on;
    logic async_now;

    always_comb begin
        clr_on    = (ar_sel[0] && !gclr_n) || (ar_sel[1] && ar_pt);
        set_on    = ap_en && ap_pt;
        async_now = clr_on || set_on;
    end

    // R1: D mode loads din_a on a global edge
    a_r1_d_capture: assert property (@(posedge clk_glb) disable iff (!gclr_n)
        (mode == 3'd0 && !clk_sel && (!ce_use || ce_pt) && !async_now)
        |=> (async_now || clk_sel || mode != 3'd0 || q == $past(din_a)));

    // R7: enable low freezes the register on global edges
    a_r7_ce_hold: assert property (@(posedge clk_glb) disable iff (!gclr_n)
        (!clk_sel && ce_use && !ce_pt && mode != 3'd4 && !async_now)
        |=> (async_now || clk_sel || mode != $past(mode) || $stable(q)));

    // R8: local clear source forces zero
    a_r8_local_clear: assert property (@(posedge clk_glb) disable iff (!gclr_n)
        (ar_sel[1] && ar_pt) |-> !q);

    // R9: enabled set term forces one when no clear
    a_r9_preset: assert property (@(posedge clk_glb) disable iff (!gclr_n)
        (set_on && !clr_on) |-> q);

    // R10: clear wins over set
    a_r10_clear_wins: assert property (@(posedge clk_glb) disable iff (!gclr_n)
        (set_on && clr_on) |-> !q);

endmodule

bind multimode_reg multimode_reg_chk u_chk (
    .clk_glb (clk_glb),
    .clk_sel (clk_sel),
    .ce_use  (ce_use),
    .ce_pt   (ce_pt),
    .mode    (mode),
    .din_a   (din_a),
    .gclr_n  (gclr_n),
    .ar_pt   (ar_pt),
    .ar_sel  (ar_sel),
    .ap_pt   (ap_pt),
    .ap_en   (ap_en),
    .q       (q)
);

// File: tb/multimode_reg_bench.sv
`timescale 1ns/1ps
module multimode_reg_bench;

    logic       clk = 1'b0;
    logic       clk_pt = 1'b0;
    logic       clk_sel = 1'b0;
    logic       ce_use = 1'b0;
    logic       ce_pt = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic       gclr_n = 1'b1;
    logic       ar_pt = 1'b0;
    logic [1:0] ar_sel = 2'd1;
    logic       ap_pt = 1'b0;
    logic       ap_en = 1'b0;
    logic       q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    multimode_reg u_multimode_reg (
        .clk_glb (clk),
        .clk_pt  (clk_pt),
        .clk_sel (clk_sel),
        .ce_use  (ce_use),
        .ce_pt   (ce_pt),
        .mode    (mode),
        .din_a   (din_a),
        .din_b   (din_b),
        .gclr_n  (gclr_n),
        .ar_pt   (ar_pt),
        .ar_sel  (ar_sel),
        .ap_pt   (ap_pt),
        .ap_en   (ap_en),
        .q       (q)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // Change clock source only while both clocks are low
    task automatic set_sel(input logic v);
        @(negedge clk);
        #1;
        clk_sel = v;
    endtask

    task automatic pulse_pt;
        clk_pt = 1'b1;
        #1;
        clk_pt = 1'b0;
        #1;
    endtask

    task automatic load(input logic v);
        mode  = 3'd0;
        din_a = v;
        tick();
    endtask

    function automatic logic model(input int m, input logic s, input logic a, input logic b);
        case (m)
            0: return a;
            1: return s ^ a;
            2: begin
                if (a && b) return !s;
                if (a) return 1'b1;
                if (b) return 1'b0;
                return s;
            end
            default: begin
                if (a && !b) return 1'b1;
                if (b && !a) return 1'b0;
                return s;
            end
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tags [4] = '{"R1", "R2", "R3", "R4"};
        // R11: global clear from power-up
        #2;
        gclr_n = 1'b0;
        #1;
        chk("R11 power-up clear", q, 1'b0);
        tick();
        chk("R11 clear held over edge", q, 1'b0);
        gclr_n = 1'b1;
        ar_sel = 2'd2;
        tick();

        // R1..R4: all modes, start states and input pairs
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int ab = 0; ab < 4; ab++) begin
                    load(s[0]);
                    mode  = m[2:0];
                    din_a = ab[1];
                    din_b = ab[0];
                    tick();
                    chk(tags[m], q, model(m, s[0], ab[1], ab[0]));
                end
            end
        end
        din_b = 1'b0;

        // R1: reserved code acts as D
        load(1'b0);
        mode = 3'd6;
        din_a = 1'b1;
        tick();
        chk("R1 reserved code", q, 1'b1);

        // R6: clock source selection
        load(1'b0);
        set_sel(1'b1);
        din_a = 1'b1;
        tick();
        tick();
        chk("R6 global edge ignored", q, 1'b0);
        pulse_pt();
        chk("R6 pt edge taken", q, 1'b1);
        din_a = 1'b0;
        pulse_pt();
        chk("R6 pt edge loads zero", q, 1'b0);
        set_sel(1'b0);
        din_a = 1'b1;
        pulse_pt();
        chk("R6 pt edge ignored", q, 1'b0);
        tick();
        chk("R6 global edge taken", q, 1'b1);

        // R7: clock enable
        load(1'b0);
        ce_use = 1'b1;
        ce_pt = 1'b0;
        din_a = 1'b1;
        tick();
        chk("R7 edge skipped", q, 1'b0);
        tick();
        chk("R7 edge skipped again", q, 1'b0);
        ce_pt = 1'b1;
        tick();
        chk("R7 edge taken", q, 1'b1);
        ce_pt = 1'b0;
        din_a = 1'b0;
        set_sel(1'b1);
        pulse_pt();
        chk("R7 enable ignored on pt clock", q, 1'b0);
        set_sel(1'b0);
        ce_use = 1'b0;
        tick();

        // R5: transparent latch
        mode = 3'd4;
        set_sel(1'b1);
        clk_pt = 1'b1;
        din_a = 1'b1;
        #1;
        chk("R5 transparent high", q, 1'b1);
        din_a = 1'b0;
        #1;
        chk("R5 transparent low", q, 1'b0);
        din_a = 1'b1;
        #1;
        clk_pt = 1'b0;
        #1;
        din_a = 1'b0;
        #1;
        chk("R5 held", q, 1'b1);
        tick();
        chk("R5 held over global edge", q, 1'b1);
        clk_pt = 1'b1;
        #1;
        chk("R5 reopens", q, 1'b0);
        clk_pt = 1'b0;
        set_sel(1'b0);
        mode = 3'd0;
        tick();

        // R8: clear source sweep
        for (int sel = 0; sel < 4; sel++) begin
            for (int g = 0; g < 2; g++) begin
                for (int p = 0; p < 2; p++) begin
                    load(1'b1);
                    ar_sel = sel[1:0];
                    gclr_n = g[0];
                    ar_pt  = p[0];
                    #1;
                    chk("R8", q,
                        !((sel[0] && !g[0]) || (sel[1] && p[0])));
                    tick();
                    ar_pt  = 1'b0;
                    gclr_n = 1'b1;
                    #1;
                end
            end
        end
        ar_sel = 2'd2;

        // R9: set term
        load(1'b0);
        ap_en = 1'b0;
        ap_pt = 1'b1;
        #1;
        chk("R9 set disabled", q, 1'b0);
        ap_pt = 1'b0;
        ap_en = 1'b1;
        ap_pt = 1'b1;
        #1;
        chk("R9 set active", q, 1'b1);
        tick();
        ap_pt = 1'b0;
        din_a = 1'b1;
        #1;
        chk("R9 set retained", q, 1'b1);
        tick();

        // R10: clear wins
        load(1'b1);
        ar_pt = 1'b1;
        ap_pt = 1'b1;
        #1;
        chk("R10 clear beats set", q, 1'b0);
        tick();
        ap_pt = 1'b0;
        #1;
        ar_pt = 1'b0;
        #1;
        chk("R10 stays clear", q, 1'b0);
        tick();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule